// File: doc/BRIEF.md
# Region-Based Memory Access Firewall

This block sits in front of a protected memory range and decides, for every transaction on each of its two memory ports, whether the access is allowed. Software programs a small set of address regions through a 32-bit register interface. Each region carries an inclusive start and end offset, measured from the base of the protected range. It also carries an enable, a secure-only attribute, an encryption request, a privilege mask per compartment and separate read and write masks per compartment. Transactions carry an address, a write flag, a secure flag, a privilege flag and a 3-bit compartment ID. The verdict comes back one clock later.

Addresses are compared on a window of bits starting at a granularity exponent, so regions are multiples of a power-of-two page. A rejected access raises a sticky flag for its port and records a syndrome and the faulting offset. Only the first fault is kept until software clears it by writing one. A global lock bit freezes the configuration until reset. A rejected configuration write made while the lock is set raises a flag of its own.

Top module: `memfw_top`

## Requirements
- R1: Region n (n = 1 to NUM_REGIONS) owns a 64-byte group at offset 0x40*n: attributes at +0x0, start at +0x4, end at +0x8, compartment masks at +0xC. Start and end store only offset bits GRAN_LSB to GRAN_LSB+WIN_W-1 and read back in those positions, with all other bits zero.
- R2: In the attribute word, bit 0 enables the region, bit 8 makes it secure-only, bit 15 requests encryption and bits 23:16 form the privilege mask. In the compartment word, bits 7:0 are read enables and bits 23:16 are write enables, with bit c (or 16+c) belonging to compartment c.
- R3: The encryption bit is stored only when the same write also sets the secure bit and ENC_SUPPORT is 1. Otherwise it reads back as 0.
- R4: An access hits a region when the access is at or above MEM_BASE, its offset has no bits set above the window, and the window field lies between start and end inclusive. An access that hits no enabled region is denied.
- R5: A read by compartment c is granted only if the hit region's read enable bit c is set. A write is granted only if write enable bit c is set.
- R6: A non-secure access to a secure-only region is denied.
- R7: An unprivileged access whose compartment has its privilege bit set in the hit region is denied.
- R8: rsp_valid and rsp_grant of a port appear exactly one clock after the request and never without one.
- R9: A denied access on port p sets status bit p+1 (status word at 0x08). It captures a syndrome at 0x20+8p (bit 0 write, bit 1 secure, bit 2 privileged, bits 10:8 compartment) and the offset at 0x24+8p. Later faults do not overwrite these until the flag is cleared.
- R10: Writing 1 to bit k of the clear word at 0x0C clears status bit k. Bits written 0 are untouched, and clearing works while locked.
- R11: Writing 1 to bit 0 of 0x00 sets the lock, which reads back as 1. While locked, writes to 0x00 and to region groups are ignored and set status bit 0.
- R12: The word at 0xFF0 reads WIN_W in bits 31:24, GRAN_LSB in bits 23:16 and NUM_REGIONS in bits 7:0.
- R13: When enabled regions overlap, the lowest-numbered hit region alone decides the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 2 | Request valid, one per port |
| req_addr | input | 2*ADDR_W | Request address, port p at bits p*ADDR_W upward |
| req_write | input | 2 | 1 = write, 0 = read |
| req_secure | input | 2 | Secure transaction flag |
| req_priv | input | 2 | Privileged transaction flag |
| req_cid | input | 6 | Compartment ID, 3 bits per port |
| rsp_valid | output | 2 | Verdict valid, one cycle after request |
| rsp_grant | output | 2 | 1 = granted, 0 = denied |

## Verification
The bench aims at the inclusive end page of a region, at an offset just past the window (a design that masked it would alias into region 1), at an address below the base, and at a disabled region. It exercises a compartment barred by only one mask bit and a privileged-only compartment next to an unrestricted one. It checks that a second fault leaves the first capture intact, that a clear of one status bit spares the others, and that overlapping regions resolve to the lower number. A design that kept encryption on a non-secure region, accepted writes after the lock, or answered in the request cycle would fail these checks.

// File: rtl/memfw_pkg.sv
package memfw_pkg;

    localparam int NUM_PORTS = 2;
    localparam int CID_W     = 3;
    localparam int NUM_CID   = 1 << CID_W;
    localparam int REG_AW    = 12;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 12'h000;
    localparam logic [REG_AW-1:0] OFS_STAT  = 12'h008;
    localparam logic [REG_AW-1:0] OFS_CLR   = 12'h00C;
    localparam logic [REG_AW-1:0] OFS_FLT   = 12'h020;
    localparam logic [REG_AW-1:0] OFS_HWCFG = 12'hFF0;

    localparam logic [5:0] RG_ATTR  = 6'h00;
    localparam logic [5:0] RG_START = 6'h04;
    localparam logic [5:0] RG_END   = 6'h08;
    localparam logic [5:0] RG_CID   = 6'h0C;

    typedef struct packed {
        logic               en;
        logic               sec;
        logic               enc;
        logic [NUM_CID-1:0] priv_mask;
        logic [NUM_CID-1:0] rd_mask;
        logic [NUM_CID-1:0] wr_mask;
    } rgn_attr_t;

    typedef struct packed {
        logic             wr;
        logic             sec;
        logic             priv;
        logic [CID_W-1:0] cid;
    } txn_attr_t;

    function automatic logic attr_permit(rgn_attr_t a, txn_attr_t t);
        logic ok;
        ok = 1'b1;
        if (a.sec && !t.sec) ok = 1'b0;
        if (a.priv_mask[t.cid] && !t.priv) ok = 1'b0;
        if (t.wr) ok = ok && a.wr_mask[t.cid];
        else      ok = ok && a.rd_mask[t.cid];
        return ok;
    endfunction

    function automatic logic [31:0] attr_word(rgn_attr_t a);
        return {8'b0, a.priv_mask, a.enc, 6'b0, a.sec, 7'b0, a.en};
    endfunction

    function automatic logic [31:0] cid_word(rgn_attr_t a);
        return {8'b0, a.wr_mask, 8'b0, a.rd_mask};
    endfunction

    function automatic logic [31:0] txn_syndrome(txn_attr_t t);
        return 32'({t.cid, 5'b0, t.priv, t.sec, t.wr});
    endfunction

endpackage

// File: rtl/memfw_regs.sv
module memfw_regs
    import memfw_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int WIN_W       = 8,
    parameter int GRAN_LSB    = 12,
    parameter bit ENC_SUPPORT = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  reg_we,
    input  logic [REG_AW-1:0]                     reg_addr,
    input  logic [31:0]                           reg_wdata,
    output rgn_attr_t [NUM_REGIONS-1:0]           attr_q,
    output logic [NUM_REGIONS-1:0][WIN_W-1:0]     start_q,
    output logic [NUM_REGIONS-1:0][WIN_W-1:0]     end_q,
    output logic                                  lock_q,
    output logic                                  lock_viol,
    output logic [2:0]                            clr_mask
);
    localparam int GRP_W = REG_AW - 6;

    logic [REG_AW-1:0] word_addr;
    logic [GRP_W-1:0]  grp;
    logic [5:0]        sub;
    logic              in_rgn_space;
    logic              wr_ok;

    assign word_addr    = {reg_addr[REG_AW-1:2], 2'b00};
    assign grp          = word_addr[REG_AW-1:6];
    assign sub          = word_addr[5:0];
    assign in_rgn_space = (grp != '0) && (int'(grp) <= NUM_REGIONS);
    assign wr_ok        = reg_we && !lock_q;
    assign lock_viol    = reg_we && lock_q && (in_rgn_space || word_addr == OFS_CTRL);
    assign clr_mask     = (reg_we && word_addr == OFS_CLR) ? reg_wdata[2:0] : 3'b000;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else if (wr_ok && word_addr == OFS_CTRL && reg_wdata[0])
            lock_q <= 1'b1;
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        localparam logic [GRP_W-1:0] GID = GRP_W'(g + 1);
        rgn_attr_t        a_q;
        logic [WIN_W-1:0] s_q;
        logic [WIN_W-1:0] e_q;
        logic             sel;

        assign sel = wr_ok && (grp == GID);

        always_ff @(posedge clk) begin
            if (rst) begin
                a_q <= '0;
                s_q <= '0;
                e_q <= '0;
            end else if (sel) begin
                case (sub)
                    RG_ATTR: begin
                        a_q.en        <= reg_wdata[0];
                        a_q.sec       <= reg_wdata[8];
                        a_q.enc       <= reg_wdata[15] & reg_wdata[8] & logic'(ENC_SUPPORT);
                        a_q.priv_mask <= reg_wdata[23:16];
                    end
                    RG_START: s_q <= reg_wdata[GRAN_LSB +: WIN_W];
                    RG_END:   e_q <= reg_wdata[GRAN_LSB +: WIN_W];
                    RG_CID: begin
                        a_q.rd_mask <= reg_wdata[7:0];
                        a_q.wr_mask <= reg_wdata[23:16];
                    end
                    default: ;
                endcase
            end
        end

        assign attr_q[g]  = a_q;
        assign start_q[g] = s_q;
        assign end_q[g]   = e_q;
    end

endmodule

// File: rtl/memfw_match.sv
module memfw_match
    import memfw_pkg::*;
#(
    parameter int                NUM_REGIONS = 4,
    parameter int                ADDR_W      = 32,
    parameter int                WIN_W       = 8,
    parameter int                GRAN_LSB    = 12,
    parameter logic [ADDR_W-1:0] MEM_BASE    = '0
) (
    input  logic                              clk,
    input  logic                              rst,
    input  rgn_attr_t [NUM_REGIONS-1:0]       attr_q,
    input  logic [NUM_REGIONS-1:0][WIN_W-1:0] start_q,
    input  logic [NUM_REGIONS-1:0][WIN_W-1:0] end_q,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  txn_attr_t                         txn,
    output logic                              grant_c,
    output logic [ADDR_W-1:0]                 offset,
    output logic                              rsp_valid,
    output logic                              rsp_grant
);
    localparam int TOP_BIT = GRAN_LSB + WIN_W;

    logic [WIN_W-1:0] field;
    logic             in_range;
    logic             hit;
    rgn_attr_t        sel;

    assign offset = req_addr - MEM_BASE;
    assign field  = offset[GRAN_LSB +: WIN_W];

    if (TOP_BIT < ADDR_W) begin : g_upper
        assign in_range = (req_addr >= MEM_BASE) && (offset[ADDR_W-1:TOP_BIT] == '0);
    end else begin : g_full
        assign in_range = (req_addr >= MEM_BASE);
    end

    // Descending scan so that the lowest-numbered hit overrides the rest.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (attr_q[i].en && field >= start_q[i] && field <= end_q[i]) begin
                hit = 1'b1;
                sel = attr_q[i];
            end
        end
    end

    assign grant_c = in_range && hit && attr_permit(sel, txn);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && grant_c;
        end
    end

endmodule

// File: rtl/memfw_fault.sv
module memfw_fault
    import memfw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              grant_c,
    input  txn_attr_t         txn,
    input  logic [ADDR_W-1:0] offset,
    input  logic              clr,
    output logic              flag_q,
    output logic [31:0]       synd_q,
    output logic [ADDR_W-1:0] addr_q
);
    logic keep;

    assign keep = flag_q && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            synd_q <= '0;
            addr_q <= '0;
        end else if (req_valid && !grant_c && !keep) begin
            flag_q <= 1'b1;
            synd_q <= txn_syndrome(txn);
            addr_q <= offset;
        end else begin
            flag_q <= keep;
        end
    end

endmodule

// File: rtl/memfw_top.sv
module memfw_top
    import memfw_pkg::*;
#(
    parameter int                NUM_REGIONS = 4,
    parameter int                ADDR_W      = 32,
    parameter int                GRAN_LSB    = 12,
    parameter int                WIN_W       = 8,
    parameter logic [ADDR_W-1:0] MEM_BASE    = ADDR_W'(32'h8000_0000),
    parameter bit                ENC_SUPPORT = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_we,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_PORTS-1:0]          req_valid,
    input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
    input  logic [NUM_PORTS-1:0]          req_write,
    input  logic [NUM_PORTS-1:0]          req_secure,
    input  logic [NUM_PORTS-1:0]          req_priv,
    input  logic [NUM_PORTS*CID_W-1:0]    req_cid,
    output logic [NUM_PORTS-1:0]          rsp_valid,
    output logic [NUM_PORTS-1:0]          rsp_grant
);
    rgn_attr_t [NUM_REGIONS-1:0]       attr_q;
    logic [NUM_REGIONS-1:0][WIN_W-1:0] start_q;
    logic [NUM_REGIONS-1:0][WIN_W-1:0] end_q;
    logic                              lock_q;
    logic                              lock_viol;
    logic [2:0]                        clr_mask;
    logic                              cfg_err_q;
    logic [NUM_PORTS-1:0]              fault_flag;
    logic [NUM_PORTS-1:0][31:0]        fault_synd;
    logic [NUM_PORTS-1:0][ADDR_W-1:0]  fault_addr;

    memfw_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .WIN_W       (WIN_W),
        .GRAN_LSB    (GRAN_LSB),
        .ENC_SUPPORT (ENC_SUPPORT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .attr_q    (attr_q),
        .start_q   (start_q),
        .end_q     (end_q),
        .lock_q    (lock_q),
        .lock_viol (lock_viol),
        .clr_mask  (clr_mask)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        txn_attr_t         txn;
        logic              grant_c;
        logic [ADDR_W-1:0] offset;

        assign txn = '{wr:   req_write[p],
                       sec:  req_secure[p],
                       priv: req_priv[p],
                       cid:  req_cid[p*CID_W +: CID_W]};

        memfw_match #(
            .NUM_REGIONS (NUM_REGIONS),
            .ADDR_W      (ADDR_W),
            .WIN_W       (WIN_W),
            .GRAN_LSB    (GRAN_LSB),
            .MEM_BASE    (MEM_BASE)
        ) u_match (
            .clk       (clk),
            .rst       (rst),
            .attr_q    (attr_q),
            .start_q   (start_q),
            .end_q     (end_q),
            .req_valid (req_valid[p]),
            .req_addr  (req_addr[p*ADDR_W +: ADDR_W]),
            .txn       (txn),
            .grant_c   (grant_c),
            .offset    (offset),
            .rsp_valid (rsp_valid[p]),
            .rsp_grant (rsp_grant[p])
        );

        memfw_fault #(
            .ADDR_W (ADDR_W)
        ) u_fault (
            .clk       (clk),
            .rst       (rst),
            .req_valid (req_valid[p]),
            .grant_c   (grant_c),
            .txn       (txn),
            .offset    (offset),
            .clr       (clr_mask[p+1]),
            .flag_q    (fault_flag[p]),
            .synd_q    (fault_synd[p]),
            .addr_q    (fault_addr[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_err_q <= 1'b0;
        else     cfg_err_q <= (cfg_err_q && !clr_mask[0]) || lock_viol;
    end

    always_comb begin
        logic [REG_AW-1:0] wa;
        wa        = {reg_addr[REG_AW-1:2], 2'b00};
        reg_rdata = '0;
        case (wa)
            OFS_CTRL:  reg_rdata = {31'b0, lock_q};
            OFS_STAT:  reg_rdata = 32'({fault_flag, cfg_err_q});
            OFS_HWCFG: reg_rdata = {8'(WIN_W), 8'(GRAN_LSB), 8'b0, 8'(NUM_REGIONS)};
            default:   ;
        endcase
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wa == OFS_FLT + REG_AW'(8 * p))     reg_rdata = fault_synd[p];
            if (wa == OFS_FLT + REG_AW'(8 * p + 4)) reg_rdata = 32'(fault_addr[p]);
        end
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (wa[REG_AW-1:6] == (REG_AW-6)'(i + 1)) begin
                case (wa[5:0])
                    RG_ATTR:  reg_rdata = attr_word(attr_q[i]);
                    RG_START: reg_rdata = 32'(start_q[i]) << GRAN_LSB;
                    RG_END:   reg_rdata = 32'(end_q[i]) << GRAN_LSB;
                    RG_CID:   reg_rdata = cid_word(attr_q[i]);
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/memfw_chk.sv
module memfw_chk
    import memfw_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_PORTS-1:0]             req_valid,
    input logic [NUM_PORTS-1:0]             rsp_valid,
    input logic [NUM_PORTS-1:0]             rsp_grant,
    input logic [NUM_PORTS-1:0]             fault_flag,
    input logic [NUM_PORTS-1:0][ADDR_W-1:0] fault_addr,
    input logic [2:0]                       clr_mask,
    input logic                             lock_q,
    input rgn_attr_t [NUM_REGIONS-1:0]      attr_q
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) req_valid[p] |=> rsp_valid[p]); // R8
        AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst) !req_valid[p] |=> !rsp_valid[p]); // R8
        AST_GRANT_HAS_VALID: assert property (@(posedge clk) disable iff (rst) rsp_grant[p] |-> rsp_valid[p]); // R8
        AST_DENY_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst) (rsp_valid[p] && !rsp_grant[p]) |-> fault_flag[p]); // R9
        AST_FIRST_FAULT_KEPT: assert property (@(posedge clk) disable iff (rst) (fault_flag[p] && $past(fault_flag[p]) && !$past(clr_mask[p+1])) |-> $stable(fault_addr[p])); // R9
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst) lock_q |=> lock_q); // R11
    AST_LOCKED_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst) $past(lock_q) |-> $stable(attr_q)); // R11

endmodule

bind memfw_top memfw_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .fault_flag (fault_flag),
    .fault_addr (fault_addr),
    .clr_mask   (clr_mask),
    .lock_q     (lock_q),
    .attr_q     (attr_q)
);

// File: tb/test_memfw_top.sv
`timescale 1ns/1ps
module test_memfw_top;
    import memfw_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  req_valid = '0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_write = '0;
    logic [1:0]  req_secure = '0;
    logic [1:0]  req_priv = '0;
    logic [5:0]  req_cid = '0;
    logic [1:0]  rsp_valid;
    logic [1:0]  rsp_grant;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    memfw_top i_memfw_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_secure(req_secure),
        .req_priv(req_priv), .req_cid(req_cid), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant)
    );

    typedef struct packed {
        logic        port;
        logic [31:0] addr;
        logic        wr;
        logic        sec;
        logic        priv;
        logic [2:0]  cid;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    // Region map: 1 = 0x00000..0x0FFFF rd all / wr cid1; 2 = secure 0x10000..0x1FFFF cid0-3;
    // 3 = single page 0x20000 with cid2 privileged-only; 4 = disabled.
    localparam vec_t VECS [14] = '{
        '{1'b0, 32'h8000_0100, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd5},  // R5 read allowed
        '{1'b0, 32'h8000_0100, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 write barred
        '{1'b0, 32'h8000_FFFF, 1'b1, 1'b0, 1'b0, 3'd1, 1'b1, 4'd4},  // R4 inclusive end
        '{1'b0, 32'h8001_0000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd6},  // R6 non-secure
        '{1'b0, 32'h8001_0000, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 4'd6},  // R6 secure
        '{1'b0, 32'h8001_8000, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 4'd5},  // R5 cid4 no write
        '{1'b0, 32'h8002_0000, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 4'd7},  // R7 unprivileged
        '{1'b0, 32'h8002_0FFF, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 4'd7},  // R7 privileged
        '{1'b0, 32'h8002_0000, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 4'd7},  // R7 other cid
        '{1'b0, 32'h8002_1000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd4},  // R4 past end
        '{1'b0, 32'h8003_0000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd4},  // R4 disabled
        '{1'b0, 32'h7FFF_F000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd4},  // R4 below base
        '{1'b0, 32'h8010_0000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd4},  // R4 above window
        '{1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd8}   // R8 port 1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic access(input int p, input logic [31:0] a, input logic wr, input logic sec,
                          input logic priv, input logic [2:0] cid,
                          output logic v, output logic g, output logic early);
        @(negedge clk);
        req_valid[p] = 1'b1;
        req_addr[p*32 +: 32] = a;
        req_write[p] = wr; req_secure[p] = sec; req_priv[p] = priv;
        req_cid[p*3 +: 3] = cid;
        #1 early = rsp_valid[p];
        @(negedge clk);
        v = rsp_valid[p];
        g = rsp_grant[p];
        req_valid[p] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic v, g, e;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state
        rreg(12'h000, d); chk("R11 reset lock", d, 32'h0);
        rreg(12'h008, d); chk("R9 reset status", d, 32'h0);
        rreg(12'h040, d); chk("R2 reset attr", d, 32'h0);
        chk("R8 reset rsp_valid", 32'(rsp_valid), 32'h0);
        rreg(12'hFF0, d); chk("R12 hwcfg", d, 32'h080C_0004);

        // Region programming
        wreg(12'h044, 32'h0000_0000); wreg(12'h048, 32'h0000_FFFF);
        wreg(12'h04C, 32'h0002_00FF); wreg(12'h040, 32'h0000_0001);
        wreg(12'h084, 32'h0001_0000); wreg(12'h088, 32'h0001_FFFF);
        wreg(12'h08C, 32'h000F_000F); wreg(12'h080, 32'h0000_8101);
        wreg(12'h0C4, 32'h0002_0000); wreg(12'h0C8, 32'h0002_0FFF);
        wreg(12'h0CC, 32'h00FF_00FF); wreg(12'h0C0, 32'h0004_8001);
        wreg(12'h104, 32'h0003_0000); wreg(12'h108, 32'h0003_FFFF);
        wreg(12'h10C, 32'h00FF_00FF); wreg(12'h100, 32'h0000_0000);

        rreg(12'h048, d); chk("R1 end window bits", d, 32'h0000_F000);
        rreg(12'h0C8, d); chk("R1 end page", d, 32'h0002_0000);
        rreg(12'h080, d); chk("R3 enc kept on secure", d, 32'h0000_8101);
        rreg(12'h0C0, d); chk("R3 enc dropped non-secure", d, 32'h0004_0001);
        rreg(12'h08C, d); chk("R2 cid masks", d, 32'h000F_000F);

        // Vector table
        for (int k = 0; k < 14; k++) begin
            access(int'(VECS[k].port), VECS[k].addr, VECS[k].wr, VECS[k].sec,
                   VECS[k].priv, VECS[k].cid, v, g, e);
            chk($sformatf("R8 vec%0d early", k), 32'(e), 32'h0);
            chk($sformatf("R8 vec%0d valid", k), 32'(v), 32'h1);
            chk($sformatf("R%0d vec%0d grant", VECS[k].req, k), 32'(g), 32'(VECS[k].exp));
        end

        // First fault on port 0 was vector 1 (write, cid0, offset 0x100)
        rreg(12'h008, d); chk("R9 status after table", d, 32'h2);
        rreg(12'h020, d); chk("R9 syndrome port0", d, 32'h1);
        rreg(12'h024, d); chk("R9 address port0", d, 32'h100);
        wreg(12'h00C, 32'h2);
        rreg(12'h008, d); chk("R10 clear port0", d, 32'h0);

        access(1, 32'h8003_0000, 1'b0, 1'b1, 1'b1, 3'd5, v, g, e);
        chk("R4 port1 deny", 32'(g), 32'h0);
        rreg(12'h008, d); chk("R9 status port1", d, 32'h4);
        rreg(12'h028, d); chk("R9 syndrome port1", d, 32'h506);
        rreg(12'h02C, d); chk("R9 address port1", d, 32'h3_0000);
        wreg(12'h00C, 32'h2);
        rreg(12'h008, d); chk("R10 other bit untouched", d, 32'h4);
        wreg(12'h00C, 32'h4);
        rreg(12'h008, d); chk("R10 clear port1", d, 32'h0);

        // Overlap: region 4 covers the whole window with full access
        wreg(12'h104, 32'h0); wreg(12'h108, 32'h000F_FFFF); wreg(12'h100, 32'h1);
        access(0, 32'h8000_0100, 1'b1, 1'b0, 1'b0, 3'd0, v, g, e);
        chk("R13 lower region decides", 32'(g), 32'h0);
        access(0, 32'h8005_0000, 1'b0, 1'b0, 1'b0, 3'd0, v, g, e);
        chk("R13 region4 alone", 32'(g), 32'h1);
        wreg(12'h00C, 32'h7);

        // Lock
        wreg(12'h000, 32'h1);
        rreg(12'h000, d); chk("R11 lock reads set", d, 32'h1);
        wreg(12'h040, 32'h0);
        rreg(12'h040, d); chk("R11 locked attr unchanged", d, 32'h1);
        rreg(12'h008, d); chk("R11 locked write flagged", d, 32'h1);
        access(0, 32'h8000_0100, 1'b0, 1'b0, 1'b0, 3'd0, v, g, e);
        chk("R11 region still active", 32'(g), 32'h1);
        wreg(12'h000, 32'h0);
        rreg(12'h000, d); chk("R11 unlock ignored", d, 32'h1);
        wreg(12'h00C, 32'h1);
        rreg(12'h008, d); chk("R10 clear while locked", d, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule